// File: doc/BRIEF.md
# Funnel Shifter with Rotate

This block is a purely combinational N-bit shifter. Every shift kind is produced by one mechanism. Two N-bit words, a high word and a low word, are joined into a 2N-bit value, and the N-bit window that begins at a right-shift position is read out. A small front end picks the two words and the window position from the operand, the requested count and the operation code. The rest of the datapath is a tree of log2(2N) multiplexer stages. Stage k either moves its input right by 2^k places or passes it through unchanged, as selected by bit k of the window position.

Logical right, arithmetic right, rotate right and logical left differ only in what feeds the high and low words. A left shift by s reads the window at position N−s. For a count of zero that position equals N, so the window is exactly the high word, which holds the operand.

Top module: `fsh_funnel_shifter`

## Requirements
- R1: With op code 2'b00 (logical right) the result equals the operand shifted right by the count, with zeros filling the vacated upper bits.
- R2: With op code 2'b01 (arithmetic right) the result equals the operand shifted right by the count, with copies of operand bit N−1 filling the vacated upper bits.
- R3: With op code 2'b10 (rotate right) bits that leave at bit 0 re-enter at bit N−1, so the result equals (operand >> s) | (operand << (N−s)).
- R4: With op code 2'b11 (logical left) the result equals the operand shifted left by the count, with zeros filling the vacated lower bits.
- R5: A count of zero returns the operand unchanged for every op code.
- R6: A rotate never changes the number of set bits in the word.
- R7: The result depends only on the present inputs. Outputs settle without any clock, and changing an input changes the result in the same evaluation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | N | Word to be shifted or rotated |
| amt_i | input | log2(N) | Shift or rotate count, 0 to N−1 |
| op_i | input | 2 | Operation: 00 logical right, 01 arithmetic right, 10 rotate right, 11 logical left |
| res_o | output | N | Shifted or rotated word |

## Verification
The bound checker checks, at every input change, the properties that hold whatever the count is. A zero count leaves the word unchanged. Logical right clears the top bit and logical left clears the bottom bit once the count is nonzero. Arithmetic right keeps the sign bit. Rotation keeps the ones count. Only the bench's sweeps show that each bit lands in exactly the right place. Those sweeps cover every count for every op code over operands chosen for their corners, including all ones, a lone sign bit and alternating patterns. The sweeps also show that a change on any input reaches the result within the same evaluation.

// File: rtl/fsh_pkg.sv
package fsh_pkg;

   typedef enum logic [1:0] {
      FSH_LSR = 2'b00,
      FSH_ASR = 2'b01,
      FSH_ROR = 2'b10,
      FSH_LSL = 2'b11
   } fsh_op_e;

endpackage

// File: rtl/fsh_word_select.sv
module fsh_word_select
   import fsh_pkg::*;
#(
   parameter int N  = 32,
   localparam int AW = $clog2(N)
) (
   input  logic [N-1:0]  opnd_i,
   input  logic [AW-1:0] amt_i,
   input  logic [1:0]    op_i,
   output logic [N-1:0]  hi_o,
   output logic [N-1:0]  lo_o,
   output logic [AW:0]   pos_o
);

   localparam logic [AW:0] FULL_POS = (AW+1)'(N);

   fsh_op_e op;
   assign op = fsh_op_e'(op_i);

   always_comb begin
      hi_o  = '0;
      lo_o  = opnd_i;
      pos_o = {1'b0, amt_i};
      unique case (op)
         FSH_LSR: begin
            hi_o = '0;
            lo_o = opnd_i;
         end
         FSH_ASR: begin
            hi_o = {N{opnd_i[N-1]}};
            lo_o = opnd_i;
         end
         FSH_ROR: begin
            hi_o = opnd_i;
            lo_o = opnd_i;
         end
         FSH_LSL: begin
            hi_o  = opnd_i;
            lo_o  = '0;
            pos_o = FULL_POS - {1'b0, amt_i};
         end
         default: begin
            hi_o = '0;
            lo_o = opnd_i;
         end
      endcase
   end

endmodule

// File: rtl/fsh_extract.sv
module fsh_extract #(
   parameter int N  = 32,
   localparam int SW = $clog2(2*N),
   localparam int DW = 2*N
) (
   input  logic [N-1:0]  hi_i,
   input  logic [N-1:0]  lo_i,
   input  logic [SW-1:0] pos_i,
   output logic [N-1:0]  win_o
);

   logic [DW-1:0] stage [0:SW];

   assign stage[0] = {hi_i, lo_i};

   for (genvar k = 0; k < SW; k++) begin : g_stage
      localparam int STEP = 1 << k;
      assign stage[k+1] = pos_i[k] ? (stage[k] >> STEP) : stage[k];
   end

   assign win_o = stage[SW][N-1:0];

   logic unused_upper;
   assign unused_upper = ^stage[SW][DW-1:N];

endmodule

// File: rtl/fsh_funnel_shifter.sv
module fsh_funnel_shifter #(
   parameter int N  = 32,
   localparam int AW = $clog2(N)
) (
   input  logic [N-1:0]  opnd_i,
   input  logic [AW-1:0] amt_i,
   input  logic [1:0]    op_i,
   output logic [N-1:0]  res_o
);

   if (N < 2 || (1 << AW) != N) begin : g_bad_width
      $error("fsh_funnel_shifter: N must be a power of two of at least 2");
   end

   logic [N-1:0] hi_w;
   logic [N-1:0] lo_w;
   logic [AW:0]  pos_w;

   fsh_word_select #(.N(N)) u_sel (
      .opnd_i (opnd_i),
      .amt_i  (amt_i),
      .op_i   (op_i),
      .hi_o   (hi_w),
      .lo_o   (lo_w),
      .pos_o  (pos_w)
   );

   fsh_extract #(.N(N)) u_ext (
      .hi_i  (hi_w),
      .lo_i  (lo_w),
      .pos_i (pos_w),
      .win_o (res_o)
   );

endmodule

// File: rtl/fsh_funnel_checker.sv
module fsh_funnel_checker
   import fsh_pkg::*;
#(
   parameter int N  = 32,
   localparam int AW = $clog2(N)
) (
   input logic [N-1:0]  opnd_i,
   input logic [AW-1:0] amt_i,
   input logic [1:0]    op_i,
   input logic [N-1:0]  res_o
);

   always_comb begin
      if (amt_i == '0)
         assert_zero_count_identity_R5: assert (res_o == opnd_i);
      if (op_i == FSH_LSR && amt_i != '0)
         assert_lsr_top_clear_R1: assert (res_o[N-1] == 1'b0);
      if (op_i == FSH_ASR)
         assert_asr_sign_kept_R2: assert (res_o[N-1] == opnd_i[N-1]);
      if (op_i == FSH_LSL && amt_i != '0)
         assert_lsl_bottom_clear_R4: assert (res_o[0] == 1'b0);
      if (op_i == FSH_ROR)
         assert_ror_ones_kept_R6: assert ($countones(res_o) == $countones(opnd_i));
   end

endmodule

bind fsh_funnel_shifter fsh_funnel_checker #(.N(N)) u_chk (
   .opnd_i (opnd_i),
   .amt_i  (amt_i),
   .op_i   (op_i),
   .res_o  (res_o)
);

// File: tb/sim_fsh_funnel_shifter.sv
`timescale 1ns/1ps
module sim_fsh_funnel_shifter;

   localparam int N  = 32;
   localparam int AW = $clog2(N);

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2.5 clk = ~clk;

   logic [N-1:0]  opnd;
   logic [AW-1:0] amt;
   logic [1:0]    op;
   logic [N-1:0]  res;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   fsh_funnel_shifter #(.N(N)) u0 (
      .opnd_i (opnd),
      .amt_i  (amt),
      .op_i   (op),
      .res_o  (res)
   );

   function automatic logic [N-1:0] model(input logic [N-1:0] a, input int s, input logic [1:0] o);
      logic [2*N-1:0] w;
      case (o)
         2'b00: model = a >> s;
         2'b01: model = N'($signed(a) >>> s);
         2'b10: begin
            w = {a, a} >> s;
            model = w[N-1:0];
         end
         default: model = a << s;
      endcase
   endfunction

   task automatic check(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s op=%0d amt=%0d opnd=%h got=%h exp=%h", req, op, amt, opnd, got, exp);
      end
   endtask

   function automatic string req_of(input logic [1:0] o, input int s);
      if (s == 0) return "R5";
      case (o)
         2'b00: return "R1";
         2'b01: return "R2";
         2'b10: return "R3";
         default: return "R4";
      endcase
   endfunction

   logic [N-1:0] pats [12];

   initial begin
      pats[0]  = '1;
      pats[1]  = 32'h8000_0000;
      pats[2]  = 32'h0000_0001;
      pats[3]  = '0;
      pats[4]  = 32'h5A5A_A5A5;
      pats[5]  = 32'h8000_0001;
      pats[6]  = 32'h7FFF_FFFF;
      pats[7]  = 32'h1234_5678;
      pats[8]  = 32'hF0F0_0F0F;
      pats[9]  = 32'hC000_0003;
      pats[10] = 32'hDEAD_BEEF;
      pats[11] = 32'h0001_8000;

      opnd = '0; amt = '0; op = 2'b00;
      repeat (3) @(posedge clk);
      rst = 1'b0;

      @(negedge clk); #1;
      check("R5", res, '0);   // idle inputs give a zero result

      for (int o = 0; o < 4; o++) begin
         for (int p = 0; p < 12; p++) begin
            for (int s = 0; s < N; s++) begin
               @(negedge clk);
               op = o[1:0]; opnd = pats[p]; amt = AW'(s);
               #1;
               check(req_of(o[1:0], s), res, model(pats[p], s, o[1:0]));
            end
         end
      end

      // R7: input change propagates with no clock edge in between
      @(negedge clk);
      op = 2'b10; opnd = 32'h0000_00FF; amt = AW'(4);
      #0.5;
      check("R7", res, 32'hF000_000F);
      amt = AW'(8);
      #0.5;
      check("R7", res, 32'hFF00_0000);
      op = 2'b11;
      #0.5;
      check("R7", res, 32'h0000_FF00);

      // R6: rotation keeps the ones count for a dense pattern
      for (int s = 0; s < N; s++) begin
         @(negedge clk);
         op = 2'b10; opnd = 32'hE000_0007; amt = AW'(s);
         #1;
         checks++;
         if ($countones(res) != 6) begin
            fails++;
            $display("FAIL R6 amt=%0d got=%0d exp=6", s, $countones(res));
         end
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired got=timeout exp=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule